// File: doc/BRIEF.md
# Sensor-Hub Host Mailbox Register Bank

This block is the byte-wide register file that sits between an external host processor and an embedded sensor-control CPU. Host traffic arrives from an abstracted serial front end as framed byte transactions. A start marker opens a frame. Each byte is flagged by a valid strobe. A stop marker closes the frame. The first byte of a frame names the register and the direction, and every later byte is a data byte that is written to, or read from, the current register index.

The host configures the addressing mode and the interrupt form, masks the interrupt requests, and posts commands with parameters. It also collects status, error codes, request flags and results. The CPU has its own write and read ports onto the same registers, and an acknowledge line that retires a posted command. One index is a read window onto an external logging FIFO, and each host read there pops one byte. The block drives an active-low interrupt line to the host.

Top module: `hub_mailbox`

## Requirements
- R1: The first byte after a transaction start is the address byte. Bit 7 set means read and bit 7 clear means write. Bits 6:0 give the register index. Host reads of indices 0x41..0x7F return 0x00, and host writes there are dropped.
- R2: When configuration bit 7 is 0, the index advances by one after every data byte and wraps from 0x7F to 0x00. When it is 1, the index holds for the whole transaction.
- R3: The configuration register at 0x00 stores only bits 7, 6 and 2, and its other bits read as 0. Bit 6 is presented on `cfg_spi3w`.
- R4: After reset: masks 0x01 and 0x02 read 0xFF, status 0x08 reads 0xFE, and every other register reads 0x00. `host_irq_n` is 1, and `cmd_posted` and `fifo_underflow` are 0.
- R5: Host writes reach only 0x00..0x02, 0x10..0x1E, and bit 0 of 0x1F. Host writes to status, request, error and result registers leave them unchanged.
- R6: A CPU write stores a byte into status 0x08, error 0x0B/0x0C or result 0x20..0x3F. A CPU write to request 0x09/0x0A ORs the byte into the register. `cpu_rdata` shows the register at `cpu_addr` with no side effect, and shows 0x00 at 0x40.
- R7: A host read of 0x09 or 0x0A returns the value and then clears that register. A bit that the CPU sets in the same cycle survives the clear.
- R8: A host write with bit 0 set to index 0x1F sets the command-posted bit, which is visible on `cmd_posted` and at bit 0 of 0x1F. `cpu_ack` clears it. A host set and an ack in the same cycle leave it set.
- R9: A host read of 0x40 returns `fifo_data` and pulses `fifo_pop` for that byte. The index never advances away from 0x40. A read there with `fifo_empty` high returns 0x00, does not pop, and sets the sticky `fifo_underflow`.
- R10: When configuration bit 2 is 1 (level form), `host_irq_n` is 0 exactly while some request bit has its mask bit at 0.
- R11: When configuration bit 2 is 0 (pulse form), `host_irq_n` goes low for 4 cycles when an unmasked request bit rises. It goes low starting one cycle after the request register changes. A masked request produces no pulse.
- R12: Bytes strobed outside a start..stop frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_start | input | 1 | Host transaction start marker |
| h_stop | input | 1 | Host transaction stop marker |
| h_valid | input | 1 | Host byte strobe |
| h_wdata | input | 8 | Host byte (address or write data) |
| h_rdata | output | 8 | Byte at the current index for a host read |
| host_irq_n | output | 1 | Active-low interrupt to the host |
| cfg_spi3w | output | 1 | Stored 3-wire select bit |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 7 | CPU register index |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Register at `cpu_addr` |
| cpu_ack | input | 1 | CPU acknowledge of a posted command |
| cmd_posted | output | 1 | Command-posted bit |
| fifo_data | input | 8 | Head byte of the logging FIFO |
| fifo_empty | input | 1 | Logging FIFO is empty |
| fifo_pop | output | 1 | Pop one byte from the logging FIFO |
| fifo_underflow | output | 1 | Sticky flag: a host read found the FIFO empty |

## Verification
A wrong index shows up on the very next host data byte, because `h_rdata` then returns a neighbour's value or a write lands in a neighbouring register. A read-back of that register exposes the write within one transaction. A wrong request, mask or mode state shows on `host_irq_n` one cycle after the CPU write or the host read that should change it: the line holds at the wrong level, or the low pulse is shorter or longer than 4 cycles. A wrong FIFO-port state shows as an extra or missing `fifo_pop` on that same byte, or as a byte from the wrong position in the stream.

// File: rtl/hub_mailbox.sv
module hub_mailbox #(
  parameter int PULSE_LEN = 4,
  parameter int CTL_N     = 15,
  parameter int RES_N     = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_start,
  input  logic       h_stop,
  input  logic       h_valid,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  output logic       host_irq_n,
  output logic       cfg_spi3w,
  input  logic       cpu_we,
  input  logic [6:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       cpu_ack,
  output logic       cmd_posted,
  input  logic [7:0] fifo_data,
  input  logic       fifo_empty,
  output logic       fifo_pop,
  output logic       fifo_underflow
);
  localparam logic [6:0] I_CFG  = 7'h00, I_MSK0 = 7'h01, I_MSK1 = 7'h02;
  localparam logic [6:0] I_STAT = 7'h08, I_REQ0 = 7'h09, I_REQ1 = 7'h0A;
  localparam logic [6:0] I_ERR0 = 7'h0B, I_ERR1 = 7'h0C;
  localparam logic [6:0] I_CTL  = 7'h10;
  localparam logic [6:0] I_CTLE = I_CTL + 7'(CTL_N - 1);
  localparam logic [6:0] I_ENT  = I_CTLE + 7'd1;
  localparam logic [6:0] I_RES  = I_ENT + 7'd1;
  localparam logic [6:0] I_RESE = I_RES + 7'(RES_N - 1);
  localparam logic [6:0] I_FIFO = I_RESE + 7'd1;
  localparam int CW  = $clog2(PULSE_LEN + 1);
  localparam int CTW = $clog2(CTL_N);
  localparam int RW  = $clog2(RES_N);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2;

  logic [1:0]  ph;
  logic        rd_mode;
  logic [6:0]  idx;
  logic        cfg_fixed, cfg_lvl;
  logic [7:0]  msk0, msk1, status, req0, req1, err0, err1;
  logic [7:0]  ctl [CTL_N];
  logic [7:0]  res [RES_N];
  logic        entry;
  logic [15:0] pend, pend_q;
  logic [CW-1:0] pcnt;

  wire addr_byte = h_valid && (ph == PH_ADDR);
  wire data_byte = h_valid && (ph == PH_DATA);
  wire hw = data_byte && !rd_mode;
  wire hr = data_byte && rd_mode;
  wire [6:0] ctl_off = idx - I_CTL;
  wire [6:0] cres_off = cpu_addr - I_RES;
  wire in_ctl = (idx >= I_CTL) && (idx <= I_CTLE);
  wire cpu_in_res = (cpu_addr >= I_RES) && (cpu_addr <= I_RESE);
  wire set_entry = hw && (idx == I_ENT) && h_wdata[0];
  wire [7:0] set0 = (cpu_we && cpu_addr == I_REQ0) ? cpu_wdata : 8'h00;
  wire [7:0] set1 = (cpu_we && cpu_addr == I_REQ1) ? cpu_wdata : 8'h00;

  function automatic logic [7:0] rd_val(input logic [6:0] a, input logic host);
    logic [6:0] off;
    off = a - I_CTL;
    if (a == I_CFG)                     return {cfg_fixed, cfg_spi3w, 3'b000, cfg_lvl, 2'b00};
    else if (a == I_MSK0)               return msk0;
    else if (a == I_MSK1)               return msk1;
    else if (a == I_STAT)               return status;
    else if (a == I_REQ0)               return req0;
    else if (a == I_REQ1)               return req1;
    else if (a == I_ERR0)               return err0;
    else if (a == I_ERR1)               return err1;
    else if (a >= I_CTL && a <= I_CTLE) return ctl[off[CTW-1:0]];
    else if (a == I_ENT)                return {7'b0, entry};
    else if (a >= I_RES && a <= I_RESE) begin
      off = a - I_RES;
      return res[off[RW-1:0]];
    end
    else if (a == I_FIFO && host)       return fifo_empty ? 8'h00 : fifo_data;
    return 8'h00;
  endfunction

  assign h_rdata   = rd_val(idx, 1'b1);
  assign cpu_rdata = rd_val(cpu_addr, 1'b0);
  assign fifo_pop  = hr && (idx == I_FIFO) && !fifo_empty;
  assign cmd_posted = entry;
  assign pend = {req1 & ~msk1, req0 & ~msk0};
  assign host_irq_n = cfg_lvl ? ~|pend : (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
      rd_mode <= 1'b0;
      idx <= '0;
    end else if (h_start) begin
      ph <= PH_ADDR;
    end else if (h_stop) begin
      ph <= PH_IDLE;
    end else if (addr_byte) begin
      ph <= PH_DATA;
      rd_mode <= h_wdata[7];
      idx <= h_wdata[6:0];
    end else if (data_byte && !cfg_fixed && idx != I_FIFO) begin
      idx <= idx + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_fixed <= 1'b0;
      cfg_spi3w <= 1'b0;
      cfg_lvl <= 1'b0;
      msk0 <= 8'hFF;
      msk1 <= 8'hFF;
      for (int i = 0; i < CTL_N; i++) ctl[i] <= 8'h00;
    end else if (hw) begin
      if (idx == I_CFG) begin
        cfg_fixed <= h_wdata[7];
        cfg_spi3w <= h_wdata[6];
        cfg_lvl <= h_wdata[2];
      end
      if (idx == I_MSK0) msk0 <= h_wdata;
      if (idx == I_MSK1) msk1 <= h_wdata;
      if (in_ctl) ctl[ctl_off[CTW-1:0]] <= h_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 8'hFE;
      err0 <= 8'h00;
      err1 <= 8'h00;
      for (int i = 0; i < RES_N; i++) res[i] <= 8'h00;
    end else if (cpu_we) begin
      if (cpu_addr == I_STAT) status <= cpu_wdata;
      if (cpu_addr == I_ERR0) err0 <= cpu_wdata;
      if (cpu_addr == I_ERR1) err1 <= cpu_wdata;
      if (cpu_in_res) res[cres_off[RW-1:0]] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req0 <= 8'h00;
      req1 <= 8'h00;
      entry <= 1'b0;
      fifo_underflow <= 1'b0;
    end else begin
      req0 <= ((hr && idx == I_REQ0) ? 8'h00 : req0) | set0;
      req1 <= ((hr && idx == I_REQ1) ? 8'h00 : req1) | set1;
      if (set_entry) entry <= 1'b1;
      else if (cpu_ack) entry <= 1'b0;
      if (hr && idx == I_FIFO && fifo_empty) fifo_underflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pcnt <= '0;
    end else begin
      pend_q <= pend;
      if (cfg_lvl) pcnt <= '0;
      else if (|(pend & ~pend_q)) pcnt <= CW'(PULSE_LEN);
      else if (pcnt != '0) pcnt <= pcnt - 1'b1;
    end
  end
endmodule

module hub_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_valid,
  input logic       cpu_ack,
  input logic       cmd_posted,
  input logic       fifo_pop,
  input logic       fifo_empty,
  input logic       fifo_underflow,
  input logic       host_irq_n,
  input logic       cfg_lvl,
  input logic       cpu_we,
  input logic [6:0] cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic [7:0] req0,
  input logic [1:0] ph,
  input logic [6:0] idx,
  input logic       rd_mode,
  input logic [7:0] h_rdata
);
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R9
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_underflow |=> fifo_underflow); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !h_valid) |=> !cmd_posted); // R8
  AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 7'h09) |=> ((req0 & $past(cpu_wdata)) == $past(cpu_wdata))); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && rd_mode && idx > 7'h40) |-> (h_rdata == 8'h00)); // R1
  AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_irq_n) && !cfg_lvl && !h_valid) |=> !host_irq_n); // R11
endmodule

bind hub_mailbox hub_mailbox_chk chk_i (.*);

// File: tb/hub_mailbox_tb_top.sv
module hub_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_start = 0, h_stop = 0, h_valid = 0;
  logic [7:0] h_wdata = 0;
  logic [7:0] h_rdata, cpu_rdata, fifo_data;
  logic host_irq_n, cfg_spi3w, cmd_posted, fifo_pop, fifo_underflow, fifo_empty;
  logic cpu_we = 0, cpu_ack = 0;
  logic [6:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;

  logic [7:0] mdl [64];
  logic [7:0] fq [16];
  logic [3:0] fh = 0, ft = 0, eh = 0;
  logic exp_uflow = 0;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_data  = fq[fh];
  assign fifo_empty = (fh == ft);
  always @(posedge clk) if (fifo_pop) fh <= fh + 4'd1;

  hub_mailbox dut_i (
    .clk(clk), .rst_n(rst_n), .h_start(h_start), .h_stop(h_stop), .h_valid(h_valid),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq_n(host_irq_n), .cfg_spi3w(cfg_spi3w),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ack(cpu_ack), .cmd_posted(cmd_posted), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .fifo_underflow(fifo_underflow)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] adv(input logic [6:0] a);
    return (mdl[0][7] || a == 7'h40) ? a : a + 7'd1;
  endfunction

  function automatic void mdl_hwrite(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'h00) mdl[0] = d & 8'hC4;
    else if (a == 7'h01 || a == 7'h02 || (a >= 7'h10 && a <= 7'h1E)) mdl[a[5:0]] = d;
    else if (a == 7'h1F && d[0]) mdl[31] = 8'h01;
  endfunction

  function automatic void mdl_cwrite(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'h08 || a == 7'h0B || a == 7'h0C || (a >= 7'h20 && a <= 7'h3F)) mdl[a[5:0]] = d;
    else if (a == 7'h09 || a == 7'h0A) mdl[a[5:0]] = mdl[a[5:0]] | d;
  endfunction

  function automatic logic [7:0] mdl_hread(input logic [6:0] a);
    logic [7:0] v;
    if (a <= 7'h3F) begin
      v = mdl[a[5:0]];
      if (a == 7'h09 || a == 7'h0A) mdl[a[5:0]] = 8'h00;
    end else if (a == 7'h40) begin
      if (eh == ft) begin v = 8'h00; exp_uflow = 1'b1; end
      else begin v = fq[eh]; eh = eh + 4'd1; end
    end else v = 8'h00;
    return v;
  endfunction

  task automatic burst(input logic rd, input logic [6:0] a, input int n,
                       input logic rnd, input logic [7:0] d0, input string tag);
    logic [6:0] cur;
    logic [7:0] d;
    @(negedge clk) h_start = 1;
    @(negedge clk) h_start = 0; h_valid = 1; h_wdata = {rd, a};
    cur = a;
    for (int k = 0; k < n; k++) begin
      logic [6:0] nxt;
      @(negedge clk);
      nxt = adv(cur);
      d = rnd ? 8'($urandom) : d0;
      h_wdata = d;
      if (rd) begin #1; check(tag, h_rdata, mdl_hread(cur)); end
      else mdl_hwrite(cur, d);
      cur = nxt;
    end
    @(negedge clk) h_valid = 0; h_stop = 1;
    @(negedge clk) h_stop = 0;
  endtask

  task automatic cpu_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk) cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk) cpu_we = 0;
    mdl_cwrite(a, d);
  endtask

  task automatic pulse_probe(input logic [7:0] d, output logic [7:0] pat);
    @(negedge clk) cpu_we = 1; cpu_addr = 7'h09; cpu_wdata = d;
    mdl_cwrite(7'h09, d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) cpu_we = 0;
      #1 pat[i] = host_irq_n;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    mdl[1] = 8'hFF; mdl[2] = 8'hFF; mdl[8] = 8'hFE;
    fq[0] = 8'hA1; fq[1] = 8'hB2; fq[2] = 8'hC3;
    for (int i = 3; i < 16; i++) fq[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R4 irq_n", {7'b0, host_irq_n}, 8'h01);
    check("R4 cmd_posted", {7'b0, cmd_posted}, 8'h00);
    check("R4 underflow", {7'b0, fifo_underflow}, 8'h00);
    burst(1, 7'h00, 13, 1, 0, "R4 reset values auto-inc R2");

    // R12: bytes outside a frame
    @(negedge clk) h_valid = 1; h_wdata = 8'h01;
    @(negedge clk) h_wdata = 8'h00;
    @(negedge clk) h_valid = 0;
    burst(1, 7'h01, 1, 1, 0, "R12 unframed bytes ignored");

    // R3
    burst(0, 7'h00, 1, 0, 8'h7F, "R3 cfg write");
    check("R3 spi3w", {7'b0, cfg_spi3w}, 8'h01);
    burst(1, 7'h00, 1, 1, 0, "R3 cfg readback");
    burst(0, 7'h00, 1, 0, 8'h00, "R3 cfg restore");

    // R5: host writes to CPU-owned registers dropped
    cpu_wr(7'h08, 8'h5A);
    burst(0, 7'h08, 5, 0, 8'h33, "R5 write to read-only");
    cpu_wr(7'h20, 8'h77);
    burst(0, 7'h20, 1, 0, 8'h11, "R5 write to result");
    burst(1, 7'h08, 5, 1, 0, "R5 read-only kept R6");
    burst(1, 7'h20, 1, 1, 0, "R5 result kept R6");

    // R1 reserved and R2 wrap
    burst(0, 7'h50, 1, 0, 8'hEE, "R1 reserved write");
    burst(1, 7'h7E, 3, 1, 0, "R1 reserved read R2 wrap");

    // R2 fixed mode
    burst(0, 7'h00, 1, 0, 8'h80, "R2 fixed on");
    burst(0, 7'h12, 3, 1, 0, "R2 fixed write");
    burst(1, 7'h12, 2, 1, 0, "R2 fixed read");
    burst(0, 7'h00, 1, 0, 8'h00, "R2 fixed off");
    burst(1, 7'h12, 2, 1, 0, "R2 auto read");

    // R6 cpu read port
    cpu_wr(7'h0B, 8'hC7);
    cpu_wr(7'h09, 8'h10);
    cpu_wr(7'h09, 8'h01);
    @(negedge clk) cpu_addr = 7'h09; #1 check("R6 cpu read OR", cpu_rdata, 8'h11);
    @(negedge clk) cpu_addr = 7'h0B; #1 check("R6 cpu read err", cpu_rdata, 8'hC7);
    @(negedge clk) cpu_addr = 7'h09; #1 check("R6 cpu read no side effect", cpu_rdata, 8'h11);

    // R7 collision: host read-clear and CPU set together
    @(negedge clk) h_start = 1;
    @(negedge clk) h_start = 0; h_valid = 1; h_wdata = 8'h89;
    @(negedge clk) h_wdata = 8'h00; cpu_we = 1; cpu_addr = 7'h09; cpu_wdata = 8'h80;
    #1 check("R7 read value", h_rdata, 8'h11);
    @(negedge clk) h_valid = 0; h_stop = 1; cpu_we = 0;
    @(negedge clk) h_stop = 0;
    mdl[9] = 8'h80;
    burst(1, 7'h09, 1, 1, 0, "R7 set survives clear");
    burst(1, 7'h09, 1, 1, 0, "R7 cleared after read");

    // R8 command entry
    burst(0, 7'h1F, 1, 0, 8'h01, "R8 post");
    check("R8 posted", {7'b0, cmd_posted}, 8'h01);
    @(negedge clk) cpu_ack = 1;
    @(negedge clk) cpu_ack = 0;
    mdl[31] = 8'h00;
    check("R8 ack clears", {7'b0, cmd_posted}, 8'h00);
    @(negedge clk) h_start = 1;
    @(negedge clk) h_start = 0; h_valid = 1; h_wdata = 8'h1F;
    @(negedge clk) h_wdata = 8'h01; cpu_ack = 1;
    @(negedge clk) h_valid = 0; cpu_ack = 0; h_stop = 1;
    #1 check("R8 set wins over ack", {7'b0, cmd_posted}, 8'h01);
    @(negedge clk) h_stop = 0;
    mdl[31] = 8'h01;
    burst(1, 7'h1F, 1, 1, 0, "R8 readback");

    // R10 level form
    burst(0, 7'h00, 1, 0, 8'h04, "R10 level cfg");
    burst(0, 7'h01, 1, 0, 8'hFE, "R10 mask");
    cpu_wr(7'h09, 8'h02);
    check("R10 masked stays high", {7'b0, host_irq_n}, 8'h01);
    cpu_wr(7'h09, 8'h01);
    check("R10 unmasked low", {7'b0, host_irq_n}, 8'h00);
    burst(1, 7'h09, 1, 1, 0, "R10 clear read");
    check("R10 high after clear", {7'b0, host_irq_n}, 8'h01);

    // R11 pulse form
    burst(0, 7'h00, 1, 0, 8'h00, "R11 pulse cfg");
    pulse_probe(8'h01, pat);
    check("R11 pulse shape", pat, 8'b1110_0001);
    burst(1, 7'h09, 1, 1, 0, "R11 clear");
    pulse_probe(8'h02, pat);
    check("R11 masked no pulse", pat, 8'hFF);
    burst(1, 7'h09, 1, 1, 0, "R11 clear2");

    // R9 FIFO port
    ft = 4'd3;
    burst(1, 7'h40, 5, 1, 0, "R9 fifo drain");
    check("R9 underflow", {7'b0, fifo_underflow}, {7'b0, exp_uflow});
    burst(1, 7'h3F, 3, 1, 0, "R9 no advance past port");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [6:0] a;
      op = int'($urandom % 4);
      a = 7'($urandom);
      case (op)
        0: burst(0, a, 1 + int'($urandom % 4), 1, 0, "R5 random write");
        1: burst(1, a, 1 + int'($urandom % 4), 1, 0, "R2 random read");
        2: cpu_wr(a, 8'($urandom));
        default: begin
          @(negedge clk) cpu_addr = a;
          #1 check("R6 random cpu read", cpu_rdata, (a <= 7'h3F) ? mdl[a[5:0]] : 8'h00);
        end
      endcase
    end
    check("R9 underflow final", {7'b0, fifo_underflow}, {7'b0, exp_uflow});
    check("R8 final posted", {7'b0, cmd_posted}, mdl[31]);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule